// File: doc/BRIEF.md
# Gated Cycle Counter Unit

This block counts clock cycles for profiling. It holds a 32-bit unsigned counter that software reaches through a single-cycle register port. The counter advances by one on every clock edge only while two enables are set together. One is a local run bit in the control register. The other is a master enable held in a separate debug register at its own offset.

Software can read the count at any moment. It can also overwrite the count while the counter runs; clearing it to zero before a measurement is the usual case. When the count wraps from all ones to zero, the block raises a single-cycle overflow event. A profiling tool can use this event to extend the count or to flag a long interval.

All read data is registered. The value returned is the one the addressed register held just before the clock edge that accepted the read.

Top module: `cyc_meter`

## Requirements
- R1: After reset the control register, count register and debug register all read 0, and the overflow event is low.
- R2: While bit 0 of the control register (offset 0x000) and bit 24 of the debug register (offset 0x010) are both 1, the count register (offset 0x004) increases by exactly 1 on every clock edge at which it is not written.
- R3: If either of those two bits is 0, the count holds its value on every edge at which it is not written.
- R4: An increment from 0xFFFFFFFF gives 0, and counting continues from there.
- R5: The overflow event is high for exactly one cycle: the cycle after the edge on which an increment wraps the count from 0xFFFFFFFF to 0. It is never raised for a software write.
- R6: A write to the count loads the written value on that edge, and that edge's increment is dropped.
- R7: A read issued in one cycle returns data in the next cycle. For the count, that data is the value held before the edge that accepted the read.
- R8: The debug register stores only bit 24. All its other bits read as 0.
- R9: Control register bits 31..1 are stored and read back unchanged, and they have no effect on counting.
- R10: A read of any other offset returns 0. A write to any other offset changes no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock; the count advances on its rising edge |
| rst_n | input | 1 | Active-low asynchronous reset |
| bus_en | input | 1 | Access request for this cycle |
| bus_we | input | 1 | 1 for a write, 0 for a read |
| bus_addr | input | ADDR_W | Byte offset of the register accessed |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, valid one cycle after the read |
| ovf_evt | output | 1 | One-cycle pulse after a counting wrap |

## Verification
The bound checker watches the counter on every cycle. It checks that the count steps by one while both enables are set, that it holds while either enable is clear, and that a write always wins over the increment. It also checks that the overflow pulse lasts one cycle and comes with a zero count, and that reads of undecoded offsets return zero. Other behaviours can only be shown by the bench's scenarios: the read-back of the count a known number of cycles after it was loaded, the masking of the debug register, the storage of the spare control bits, the wrap to a small value, and the case where a write lands on the very edge that would otherwise overflow.

// File: rtl/cyc_meter.sv
module cyc_meter #(
  parameter int ADDR_W  = 12,
  parameter int DBG_BIT = 24
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_en,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [31:0]       bus_wdata,
  output logic [31:0]       bus_rdata,
  output logic              ovf_evt
);
  localparam logic [ADDR_W-1:0] OFS_CTRL = ADDR_W'('h000);
  localparam logic [ADDR_W-1:0] OFS_CNT  = ADDR_W'('h004);
  localparam logic [ADDR_W-1:0] OFS_DBG  = ADDR_W'('h010);
  localparam logic [31:0]       CNT_MAX  = '1;

  logic [31:0] ctrl_q;
  logic [31:0] cnt_q;
  logic        dbg_en;
  logic        ovf_q;
  logic [31:0] rd_mux;

  wire hit_ctrl = bus_addr == OFS_CTRL;
  wire hit_cnt  = bus_addr == OFS_CNT;
  wire hit_dbg  = bus_addr == OFS_DBG;
  wire wr       = bus_en & bus_we;
  wire rd       = bus_en & ~bus_we;
  wire cnt_wr   = wr & hit_cnt;
  wire run      = ctrl_q[0] & dbg_en;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctrl_q <= '0;
      dbg_en <= 1'b0;
    end else begin
      if (wr && hit_ctrl) ctrl_q <= bus_wdata;
      if (wr && hit_dbg)  dbg_en <= bus_wdata[DBG_BIT];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
      ovf_q <= 1'b0;
    end else begin
      ovf_q <= run && !cnt_wr && (cnt_q == CNT_MAX);
      if (cnt_wr)   cnt_q <= bus_wdata;
      else if (run) cnt_q <= cnt_q + 32'd1;
    end
  end

  always_comb begin
    rd_mux = '0;
    if (hit_ctrl) rd_mux = ctrl_q;
    if (hit_cnt)  rd_mux = cnt_q;
    if (hit_dbg)  rd_mux[DBG_BIT] = dbg_en;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) bus_rdata <= '0;
    else        bus_rdata <= rd ? rd_mux : '0;
  end

  assign ovf_evt = ovf_q;
endmodule

// File: rtl/cyc_meter_chk.sv
module cyc_meter_chk #(
  parameter int ADDR_W = 12
) (
  input logic              clk,
  input logic              rst_n,
  input logic              bus_en,
  input logic              bus_we,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [31:0]       bus_wdata,
  input logic [31:0]       bus_rdata,
  input logic              ovf_evt,
  input logic [31:0]       cnt_q,
  input logic              loc_en,
  input logic              mst_en
);
  wire load  = bus_en && bus_we && bus_addr == ADDR_W'('h004);
  wire undec = bus_addr != ADDR_W'('h000) && bus_addr != ADDR_W'('h004) && bus_addr != ADDR_W'('h010);

  AST_COUNT_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (loc_en && mst_en && !load) |=> cnt_q == $past(cnt_q) + 32'd1); // R2
  AST_COUNT_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (!(loc_en && mst_en) && !load) |=> $stable(cnt_q)); // R3
  AST_WRITE_WINS: assert property (@(posedge clk) disable iff (!rst_n)
    load |=> cnt_q == $past(bus_wdata)); // R6
  AST_OVF_SINGLE: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_evt |=> !ovf_evt); // R5
  AST_OVF_AT_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    ovf_evt |-> cnt_q == 32'd0); // R4
  AST_UNDEC_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_en && !bus_we && undec) |=> bus_rdata == 32'd0); // R10
endmodule

bind cyc_meter cyc_meter_chk #(.ADDR_W(ADDR_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we),
  .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
  .ovf_evt(ovf_evt), .cnt_q(cnt_q), .loc_en(ctrl_q[0]), .mst_en(dbg_en)
);

// File: tb/sim_cyc_meter.sv
module sim_cyc_meter;
  localparam int CLK_PERIOD = 10;
  localparam int AW = 12;
  localparam int NV = 7;
  localparam logic [AW-1:0] A_CTRL = 12'h000, A_CNT = 12'h004, A_DBG = 12'h010, A_BAD = 12'h020;

  localparam logic [31:0] V_DBG  [NV] = '{32'h0100_0000, 32'h0000_0000, 32'h0100_0000, 32'h0100_0000,
                                          32'hFEFF_FFFF, 32'h0100_0000, 32'h0100_0000};
  localparam logic [31:0] V_CTRL [NV] = '{32'h1, 32'h1, 32'h0, 32'hFFFF_FFFE, 32'h1, 32'h8000_0001, 32'h1};
  localparam logic [31:0] V_INIT [NV] = '{32'd100, 32'd100, 32'd7, 32'd50, 32'd9, 32'hFFFF_FFFD, 32'd0};
  localparam int          V_IDLE [NV] = '{5, 5, 3, 4, 4, 5, 0};
  localparam logic [31:0] V_EXP  [NV] = '{32'd105, 32'd100, 32'd7, 32'd50, 32'd9, 32'd2, 32'd0};

  logic clk = 1'b0, rst_n = 1'b0, bus_en = 1'b0, bus_we = 1'b0;
  logic [AW-1:0] bus_addr = '0;
  logic [31:0] bus_wdata = '0, bus_rdata;
  logic ovf_evt;
  int n_chk = 0, n_bad = 0;
  logic [31:0] rv;

  cyc_meter #(.ADDR_W(AW)) u0 (.clk(clk), .rst_n(rst_n), .bus_en(bus_en), .bus_we(bus_we),
    .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .ovf_evt(ovf_evt));

  always #(CLK_PERIOD/2) clk = ~clk;

  task automatic chk(input string req, input logic [31:0] got, input logic [31:0] exp);
    n_chk++;
    if (got !== exp) begin
      n_bad++;
      $display("FAIL %s: got %h expected %h", req, got, exp);
    end
  endtask

  task automatic wr(input logic [AW-1:0] a, input logic [31:0] d);
    bus_en = 1'b1; bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_en = 1'b0; bus_we = 1'b0;
  endtask

  task automatic rd(input logic [AW-1:0] a, output logic [31:0] d);
    bus_en = 1'b1; bus_we = 1'b0; bus_addr = a;
    @(negedge clk);
    bus_en = 1'b0;
    d = bus_rdata;
  endtask

  initial begin
    #(CLK_PERIOD * 20000);
    n_bad++;
    $display("FAIL watchdog: got timeout expected completion");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 ovf", {31'd0, ovf_evt}, 32'd0);
    rd(A_CTRL, rv); chk("R1 ctrl", rv, 32'd0);
    rd(A_CNT, rv);  chk("R1 cnt", rv, 32'd0);
    rd(A_DBG, rv);  chk("R1 dbg", rv, 32'd0);

    for (int i = 0; i < NV; i++) begin
      wr(A_DBG, V_DBG[i]);
      wr(A_CTRL, V_CTRL[i]);
      wr(A_CNT, V_INIT[i]);
      repeat (V_IDLE[i]) @(negedge clk);
      rd(A_CNT, rv);
      chk($sformatf("R2 R3 R4 R6 R7 vector %0d", i), rv, V_EXP[i]);
    end

    wr(A_DBG, 32'hFFFF_FFFF);
    rd(A_DBG, rv); chk("R8 dbg mask", rv, 32'h0100_0000);
    wr(A_CTRL, 32'hABCD_1230);
    rd(A_CTRL, rv); chk("R9 ctrl readback", rv, 32'hABCD_1230);
    wr(A_CNT, 32'd77);
    @(negedge clk);
    rd(A_CNT, rv); chk("R9 no count on spare bits", rv, 32'd77);

    wr(A_CTRL, 32'h1);
    wr(A_CNT, 32'hFFFF_FFFE);
    @(negedge clk);
    chk("R5 ovf before wrap", {31'd0, ovf_evt}, 32'd0);
    @(negedge clk);
    chk("R5 ovf at wrap", {31'd0, ovf_evt}, 32'd1);
    @(negedge clk);
    chk("R5 ovf one cycle", {31'd0, ovf_evt}, 32'd0);

    wr(A_CNT, 32'hFFFF_FFFF);
    wr(A_CNT, 32'd5);
    chk("R6 no ovf on overwrite", {31'd0, ovf_evt}, 32'd0);
    rd(A_CNT, rv); chk("R6 write beats increment", rv, 32'd5);

    wr(A_CTRL, 32'h0);
    wr(A_BAD, 32'hFFFF_FFFF);
    rd(A_BAD, rv);  chk("R10 undecoded read", rv, 32'd0);
    rd(A_CTRL, rv); chk("R10 ctrl untouched", rv, 32'd0);
    rd(A_DBG, rv);  chk("R10 dbg untouched", rv, 32'h0100_0000);
    rd(A_CNT, rv);  chk("R10 cnt untouched", rv, 32'd7);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule